// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block is the host-side controller that takes a byte-wide parallel flash device through a complete chip erase. A single `start` pulse begins a three-phase run. First, every byte is pre-programmed to 00h, and each byte is checked with a program-verify read before the next one. Second, the device receives an erase command pair and the controller waits a fixed erase time. Third, the controller walks the address space with erase-verify setup writes and verify reads. A byte that does not read back as FFh causes another erase pulse. Verification then continues from that same byte.

The controller always ends the run by writing the reset command, which takes the device out of verify mode. It then reports either `done` or `fail` for one clock. A run fails in two cases: the erase-pulse budget is used up, or a byte still cannot be programmed after its allowed program attempts. Bus timing is deliberately simple. Every device access is a strobe held for `CYC_CLKS` clocks, with at least two quiet clocks between accesses. Read data is captured on the last strobed clock.

Top module: `erase_seq`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `flash_we` and `flash_oe` are all low. A `start` pulse received while `busy` is high has no effect on the bus trace or on the outcome.
- R2: Pre-programming goes through the addresses in ascending order from 0. For each address the controller writes 40h, then writes 00h, then writes C0h, then reads, all at that address. A read value of 00h moves on to the next address.
- R3: A program-verify read that is not 00h repeats the four accesses of R2 on the same address. Up to `PROG_TRIES` attempts per byte are allowed. A failure on the last allowed attempt ends the run as a failure (R8).
- R4: Once the last address has pre-programmed, the controller writes 20h twice in a row. This is one erase pulse.
- R5: Between the end of the second 20h write and the first clock of the next verify access, exactly `ERASE_CLKS` extra quiet clocks pass, in addition to the normal inter-access gap.
- R6: Each byte is verified by writing A0h at its address and then reading the same address. A value of FFh moves on to the next address.
- R7: A verify read that is not FFh triggers another erase pulse (two 20h writes and the erase wait). After that pulse, verification resumes at the failing address, not at address 0.
- R8: At most `MAX_PULSES` erase pulses are issued. A verify failure after the last allowed pulse, or a program failure under R3, leads to a reset-command write followed by `fail` high for exactly one clock, with `done` staying low.
- R9: When the last address verifies as FFh, the controller writes FFh. In the clock after that write's gap, `done` is high for exactly one clock and `busy` is low.
- R10: Every access holds exactly one of `flash_we`/`flash_oe` high for exactly `CYC_CLKS` clocks, with address and write data stable. At least two clocks with both strobes low separate consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full erase run (only taken when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-clock pulse: run finished with the whole array erased |
| fail | output | 1 | One-clock pulse: run aborted on a program or erase limit |
| flash_we | output | 1 | Write strobe to the device |
| flash_oe | output | 1 | Read strobe to the device |
| flash_addr | output | ADDR_W | Device byte address |
| flash_wdata | output | 8 | Command or data byte written to the device |
| flash_rdata | input | 8 | Byte returned by the device during a read |

## Verification
A wrong internal state shows up on the bus within one access: a wrong phase or counter changes the next strobe's command byte or address, or leaves the ERASE_CLKS pause the wrong length. The bench gives its device model a scripted number of program attempts and erase pulses per byte. A behavioural model then predicts every clock of the strobes, address, data and status. Because the comparison runs clock by clock, a resume at the wrong address, a miscounted limit, or an off-by-one erase wait is reported in the first clock where it differs. That clock comes no later than the next access.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] CMD_PROG      = 8'h40;
   localparam logic [BYTE_W-1:0] CMD_PROG_CHK  = 8'hC0;
   localparam logic [BYTE_W-1:0] CMD_ERASE     = 8'h20;
   localparam logic [BYTE_W-1:0] CMD_ERASE_CHK = 8'hA0;
   localparam logic [BYTE_W-1:0] CMD_RESET     = 8'hFF;
   localparam logic [BYTE_W-1:0] VAL_ZERO      = 8'h00;
   localparam logic [BYTE_W-1:0] VAL_BLANK     = 8'hFF;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_PG_CMD,
      SQ_PG_DATA,
      SQ_PG_VCMD,
      SQ_PG_VRD,
      SQ_ER_CMD1,
      SQ_ER_CMD2,
      SQ_ER_WAIT,
      SQ_EV_CMD,
      SQ_EV_RD,
      SQ_TERM
   } seq_state_t;

   typedef enum logic [1:0] {
      BX_IDLE,
      BX_ACT,
      BX_GAP
   } bus_state_t;

endpackage

// File: rtl/erase_seq_cnt.sv
module erase_seq_cnt #(
   parameter int WIDTH    = 8,
   parameter bit COUNT_UP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             step,
   output logic [WIDTH-1:0] count
);

   logic [WIDTH-1:0] cnt_q;

   generate
      if (COUNT_UP) begin : g_up
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= load_val;
            end else if (step && (cnt_q != {WIDTH{1'b1}})) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin : g_down
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= load_val;
            end else if (step && (cnt_q != '0)) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   endgenerate

   assign count = cnt_q;

endmodule

// File: rtl/erase_seq_bus.sv
module erase_seq_bus
   import erase_seq_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int CYC_CLKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BYTE_W-1:0] data_in,
   output logic              ack,
   output logic [BYTE_W-1:0] rdata_q,
   output logic              bus_we,
   output logic              bus_oe,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BYTE_W-1:0] bus_wdata,
   input  logic [BYTE_W-1:0] bus_rdata
);

   bus_state_t st_q;
   logic       last_beat;

   generate
      if (CYC_CLKS == 1) begin : g_single
         assign last_beat = 1'b1;
      end else begin : g_multi
         localparam int BW = $clog2(CYC_CLKS);
         logic [BW-1:0] beat_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               beat_q <= '0;
            end else if (st_q == BX_IDLE && req) begin
               beat_q <= BW'(CYC_CLKS - 1);
            end else if (st_q == BX_ACT && beat_q != '0) begin
               beat_q <= beat_q - 1'b1;
            end
         end
         assign last_beat = (beat_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= BX_IDLE;
         bus_we    <= 1'b0;
         bus_oe    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         rdata_q   <= '0;
      end else begin
         case (st_q)
            BX_IDLE: begin
               if (req) begin
                  st_q      <= BX_ACT;
                  bus_we    <= !rd;
                  bus_oe    <= rd;
                  bus_addr  <= addr_in;
                  bus_wdata <= data_in;
               end
            end
            BX_ACT: begin
               if (last_beat) begin
                  st_q   <= BX_GAP;
                  bus_we <= 1'b0;
                  bus_oe <= 1'b0;
                  if (bus_oe) begin
                     rdata_q <= bus_rdata;
                  end
               end
            end
            default: begin
               st_q <= BX_IDLE;
            end
         endcase
      end
   end

   assign ack = (st_q == BX_GAP);

endmodule

// File: rtl/erase_seq.sv
module erase_seq
   import erase_seq_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int CYC_CLKS   = 4,
   parameter int ERASE_CLKS = 1250,
   parameter int MAX_PULSES = 1000,
   parameter int PROG_TRIES = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              flash_we,
   output logic              flash_oe,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [7:0]        flash_wdata,
   input  logic [7:0]        flash_rdata
);

   localparam int PULSE_W = $clog2(MAX_PULSES + 1);
   localparam int TRY_W   = $clog2(PROG_TRIES + 1);
   localparam int WAIT_W  = $clog2(ERASE_CLKS + 1);
   localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

   initial begin
      assert (ADDR_W >= 1)     else $fatal(1, "ADDR_W must be at least 1");
      assert (CYC_CLKS >= 1)   else $fatal(1, "CYC_CLKS must be at least 1");
      assert (ERASE_CLKS >= 1) else $fatal(1, "ERASE_CLKS must be at least 1");
      assert (MAX_PULSES >= 1) else $fatal(1, "MAX_PULSES must be at least 1");
      assert (PROG_TRIES >= 1) else $fatal(1, "PROG_TRIES must be at least 1");
   end

   seq_state_t        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic              abort_q;
   logic              done_q;
   logic              fail_q;

   logic              op_req;
   logic              op_rd;
   logic [BYTE_W-1:0] op_data;
   logic              op_ack;
   logic [BYTE_W-1:0] rd_byte;

   logic [PULSE_W-1:0] pulses;
   logic [TRY_W-1:0]   misses;
   logic [WAIT_W-1:0]  wait_left;

   logic at_last, prog_ok, blank_ok, pulses_spent, tries_spent;
   logic try_clr, try_step, pulse_clr, pulse_step, wait_load, wait_step;

   assign at_last      = (addr_q == LAST_ADDR);
   assign prog_ok      = (rd_byte == VAL_ZERO);
   assign blank_ok     = (rd_byte == VAL_BLANK);
   assign pulses_spent = (pulses == PULSE_W'(MAX_PULSES));
   assign tries_spent  = (misses == TRY_W'(PROG_TRIES - 1));

   always_comb begin
      op_req  = 1'b1;
      op_rd   = 1'b0;
      op_data = CMD_RESET;
      case (st_q)
         SQ_PG_CMD:  op_data = CMD_PROG;
         SQ_PG_DATA: op_data = VAL_ZERO;
         SQ_PG_VCMD: op_data = CMD_PROG_CHK;
         SQ_PG_VRD:  op_rd   = 1'b1;
         SQ_ER_CMD1: op_data = CMD_ERASE;
         SQ_ER_CMD2: op_data = CMD_ERASE;
         SQ_EV_CMD:  op_data = CMD_ERASE_CHK;
         SQ_EV_RD:   op_rd   = 1'b1;
         SQ_TERM:    op_data = CMD_RESET;
         default:    op_req  = 1'b0;
      endcase
   end

   always_comb begin
      try_clr    = (st_q == SQ_IDLE && start) || (st_q == SQ_PG_VRD && op_ack && prog_ok);
      try_step   = (st_q == SQ_PG_VRD) && op_ack && !prog_ok && !tries_spent;
      pulse_clr  = (st_q == SQ_IDLE) && start;
      pulse_step = (st_q == SQ_ER_CMD2) && op_ack;
      wait_load  = (st_q == SQ_ER_CMD2) && op_ack;
      wait_step  = (st_q == SQ_ER_WAIT);
   end

   erase_seq_cnt #(.WIDTH(TRY_W), .COUNT_UP(1'b1)) u_tries (
      .clk(clk), .rst_n(rst_n), .clr(try_clr), .load(1'b0),
      .load_val('0), .step(try_step), .count(misses)
   );

   erase_seq_cnt #(.WIDTH(PULSE_W), .COUNT_UP(1'b1)) u_pulses (
      .clk(clk), .rst_n(rst_n), .clr(pulse_clr), .load(1'b0),
      .load_val('0), .step(pulse_step), .count(pulses)
   );

   erase_seq_cnt #(.WIDTH(WAIT_W), .COUNT_UP(1'b0)) u_wait (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .load(wait_load),
      .load_val(WAIT_W'(ERASE_CLKS - 1)), .step(wait_step), .count(wait_left)
   );

   erase_seq_bus #(.ADDR_W(ADDR_W), .CYC_CLKS(CYC_CLKS)) u_bus (
      .clk(clk), .rst_n(rst_n), .req(op_req), .rd(op_rd),
      .addr_in(addr_q), .data_in(op_data), .ack(op_ack), .rdata_q(rd_byte),
      .bus_we(flash_we), .bus_oe(flash_oe), .bus_addr(flash_addr),
      .bus_wdata(flash_wdata), .bus_rdata(flash_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         addr_q  <= '0;
         abort_q <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  st_q    <= SQ_PG_CMD;
                  addr_q  <= '0;
                  abort_q <= 1'b0;
               end
            end
            SQ_PG_CMD:  if (op_ack) st_q <= SQ_PG_DATA;
            SQ_PG_DATA: if (op_ack) st_q <= SQ_PG_VCMD;
            SQ_PG_VCMD: if (op_ack) st_q <= SQ_PG_VRD;
            SQ_PG_VRD: begin
               if (op_ack) begin
                  if (prog_ok) begin
                     if (at_last) begin
                        addr_q <= '0;
                        st_q   <= SQ_ER_CMD1;
                     end else begin
                        addr_q <= addr_q + 1'b1;
                        st_q   <= SQ_PG_CMD;
                     end
                  end else if (tries_spent) begin
                     abort_q <= 1'b1;
                     st_q    <= SQ_TERM;
                  end else begin
                     st_q <= SQ_PG_CMD;
                  end
               end
            end
            SQ_ER_CMD1: if (op_ack) st_q <= SQ_ER_CMD2;
            SQ_ER_CMD2: if (op_ack) st_q <= SQ_ER_WAIT;
            SQ_ER_WAIT: if (wait_left == '0) st_q <= SQ_EV_CMD;
            SQ_EV_CMD:  if (op_ack) st_q <= SQ_EV_RD;
            SQ_EV_RD: begin
               if (op_ack) begin
                  if (blank_ok) begin
                     if (at_last) begin
                        st_q <= SQ_TERM;
                     end else begin
                        addr_q <= addr_q + 1'b1;
                        st_q   <= SQ_EV_CMD;
                     end
                  end else if (pulses_spent) begin
                     abort_q <= 1'b1;
                     st_q    <= SQ_TERM;
                  end else begin
                     st_q <= SQ_ER_CMD1;
                  end
               end
            end
            SQ_TERM: begin
               if (op_ack) begin
                  st_q   <= SQ_IDLE;
                  done_q <= !abort_q;
                  fail_q <= abort_q;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy = (st_q != SQ_IDLE);
   assign done = done_q;
   assign fail = fail_q;

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
   parameter int ADDR_W   = 18,
   parameter int CYC_CLKS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              flash_we,
   input logic              flash_oe,
   input logic [ADDR_W-1:0] flash_addr,
   input logic [7:0]        flash_wdata
);

   localparam int RW = $clog2(CYC_CLKS + 2) + 1;

   logic          strobe;
   logic [RW-1:0] run_len;
   logic [1:0]    low_len;
   logic [7:0]    last_wr;

   assign strobe = flash_we || flash_oe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         low_len <= 2'd3;
         last_wr <= '0;
      end else begin
         run_len <= strobe ? run_len + 1'b1 : '0;
         low_len <= strobe ? 2'd0 : ((low_len == 2'd3) ? 2'd3 : low_len + 1'b1);
         if (flash_we) last_wr <= flash_wdata;
      end
   end

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_we && flash_oe));

   p_run_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (run_len < RW'(CYC_CLKS)));

   p_run_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && run_len != '0) |-> (run_len == RW'(CYC_CLKS)));

   p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> (low_len >= 2'd2));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_we && $past(flash_we)) |-> ($stable(flash_addr) && $stable(flash_wdata)));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !strobe);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !fail && last_wr == 8'hFF));

   p_fail_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> !fail);

   p_fail_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (!busy && last_wr == 8'hFF));

endmodule

bind erase_seq erase_seq_chk #(.ADDR_W(ADDR_W), .CYC_CLKS(CYC_CLKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
   .flash_we(flash_we), .flash_oe(flash_oe), .flash_addr(flash_addr),
   .flash_wdata(flash_wdata)
);

// File: tb/sim_erase_seq.sv
module sim_erase_seq;

   localparam int AW  = 3;
   localparam int N   = 1 << AW;
   localparam int CYC = 2;
   localparam int EW  = 5;
   localparam int MP  = 4;
   localparam int PT  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          busy, done, fail, we, oe;
   logic [AW-1:0] addr;
   logic [7:0]    wdata;
   logic [7:0]    rdata;

   always #4 clk = ~clk;

   erase_seq #(.ADDR_W(AW), .CYC_CLKS(CYC), .ERASE_CLKS(EW),
               .MAX_PULSES(MP), .PROG_TRIES(PT)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .fail(fail), .flash_we(we), .flash_oe(oe), .flash_addr(addr),
      .flash_wdata(wdata), .flash_rdata(rdata)
   );

   int checks = 0;
   int errors = 0;
   int need_p[N];
   int need_e[N];

   // Behavioural flash device: counts program attempts and erase pulses.
   int         fl_prog[N];
   int         fl_erase;
   int         fl_mode;
   int         fl_a;
   logic       fl_prev_we;
   logic [7:0] fl_lat;
   logic       fl_clr = 1'b1;

   always @(negedge clk) begin
      if (fl_clr) begin
         for (int i = 0; i < N; i++) fl_prog[i] = 0;
         fl_erase = 0; fl_mode = 0; fl_a = 0; fl_prev_we = 1'b0; fl_lat = 8'h00;
      end else begin
         if (fl_prev_we && !we) begin
            if (fl_mode == 1) begin
               fl_prog[fl_a] = fl_prog[fl_a] + 1;
               fl_mode = 0;
            end else begin
               case (fl_lat)
                  8'h40: fl_mode = 1;
                  8'hC0: fl_mode = 2;
                  8'h20: begin
                     if (fl_mode == 3) begin fl_erase = fl_erase + 1; fl_mode = 4; end
                     else fl_mode = 3;
                  end
                  8'hA0: fl_mode = 5;
                  default: fl_mode = 0;
               endcase
            end
         end
         if (we) begin fl_lat = wdata; fl_a = int'(addr); end
         fl_prev_we = we;
      end
   end

   always_comb begin
      case (fl_mode)
         2: rdata = (fl_prog[int'(addr)] >= need_p[int'(addr)]) ? 8'h00 : 8'h10;
         5: rdata = (fl_erase >= need_e[int'(addr)]) ? 8'hFF : 8'h3C;
         default: rdata = 8'h55;
      endcase
   end

   // Expected per-clock trace built from the requirements.
   typedef struct packed {
      logic busy, done, fail, we, oe;
      logic [AW-1:0] addr;
      logic [7:0] wd;
   } exp_t;

   exp_t  q[$];
   string qt[$];

   task automatic push(exp_t e, string t);
      q.push_back(e);
      qt.push_back(t);
   endtask

   task automatic push_op(bit rd, int a, int d, string t);
      exp_t e;
      e = '{busy: 1'b1, done: 1'b0, fail: 1'b0, we: 1'b0, oe: 1'b0,
            addr: AW'(a), wd: 8'(d)};
      push(e, t);
      e.we = !rd; e.oe = rd;
      for (int k = 0; k < CYC; k++) push(e, t);
      e.we = 1'b0; e.oe = 1'b0;
      push(e, t);
   endtask

   task automatic push_erase(int a, bit again);
      exp_t e;
      push_op(0, a, 8'h20, again ? "R7" : "R4");
      push_op(0, a, 8'h20, again ? "R7" : "R4");
      e = '{busy: 1'b1, done: 1'b0, fail: 1'b0, we: 1'b0, oe: 1'b0, addr: '0, wd: '0};
      for (int k = 0; k < EW; k++) push(e, "R5");
   endtask

   task automatic build_ref();
      int  a = 0;
      int  tries;
      int  pulses = 0;
      bit  bad = 0;
      bit  fin = 0;
      exp_t e;
      while (!fin && !bad) begin
         tries = 1;
         while (1) begin
            push_op(0, a, 8'h40, tries > 1 ? "R3" : "R2");
            push_op(0, a, 8'h00, tries > 1 ? "R3" : "R2");
            push_op(0, a, 8'hC0, tries > 1 ? "R3" : "R2");
            push_op(1, a, 0,     tries > 1 ? "R3" : "R2");
            if (tries >= need_p[a]) break;
            if (tries == PT) begin bad = 1; break; end
            tries++;
         end
         if (!bad) begin
            if (a == N - 1) fin = 1;
            else a++;
         end
      end
      if (!bad) begin
         a = 0;
         push_erase(a, 0);
         pulses = 1;
         fin = 0;
         while (!fin && !bad) begin
            push_op(0, a, 8'hA0, "R6");
            push_op(1, a, 0, "R6");
            if (pulses >= need_e[a]) begin
               if (a == N - 1) fin = 1;
               else a++;
            end else if (pulses == MP) begin
               bad = 1;
            end else begin
               push_erase(a, 1);
               pulses++;
            end
         end
      end
      push_op(0, a, 8'hFF, bad ? "R8" : "R9");
      e = '{busy: 1'b0, done: !bad, fail: bad, we: 1'b0, oe: 1'b0, addr: '0, wd: '0};
      push(e, bad ? "R8" : "R9");
      e.done = 1'b0; e.fail = 1'b0;
      push(e, bad ? "R8" : "R9");
   endtask

   task automatic set_needs(int pv, int ev);
      for (int i = 0; i < N; i++) begin need_p[i] = pv; need_e[i] = ev; end
   endtask

   // Runs one erase; start pokes at poke_a/poke_b land while busy (R1).
   task automatic run_case(string name, int poke_a, int poke_b);
      exp_t  e;
      string t;
      int    idx = 0;
      bit    bad;
      q.delete(); qt.delete();
      build_ref();
      fl_clr = 1'b1;
      @(negedge clk); @(negedge clk);
      fl_clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (q.size() > 0) begin
         e = q.pop_front();
         t = qt.pop_front();
         checks++;
         bad = (busy !== e.busy) || (done !== e.done) || (fail !== e.fail) ||
               (we !== e.we) || (oe !== e.oe);
         if (e.we && (addr !== e.addr || wdata !== e.wd)) bad = 1;
         if (e.oe && (addr !== e.addr)) bad = 1;
         if (bad) begin
            errors++;
            $display("FAIL %s %s clk %0d: got busy%b done%b fail%b we%b oe%b a%0h d%02h exp busy%b done%b fail%b we%b oe%b a%0h d%02h",
                     t, name, idx, busy, done, fail, we, oe, addr, wdata,
                     e.busy, e.done, e.fail, e.we, e.oe, e.addr, e.wd);
         end
         idx++;
         start = (idx == poke_a) || (idx == poke_b);
         @(negedge clk);
      end
      start = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_bit(string t, string what, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b", t, what, got, exp);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: quiet outputs while and just after reset
      check_bit("R1", "busy", busy, 1'b0);
      check_bit("R1", "done", done, 1'b0);
      check_bit("R1", "fail", fail, 1'b0);
      check_bit("R1", "we", we, 1'b0);
      check_bit("R1", "oe", oe, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_bit("R1", "busy after release", busy, 1'b0);

      // R2 R4 R5 R6 R9: every byte programs and erases first time
      set_needs(1, 1);
      run_case("clean", -1, -1);

      // R3 R7 and R1 (start while busy ignored): retries and resumes
      set_needs(1, 1);
      need_p[2] = 2; need_e[3] = 2; need_e[6] = 3;
      run_case("resume", 10, 150);

      // R8: byte 5 never erases within the pulse budget
      set_needs(1, 1);
      need_e[5] = MP + 1;
      run_case("pulse_limit", -1, -1);

      // R3 R8: byte 1 never programs within its tries
      set_needs(1, 1);
      need_p[1] = PT + 1;
      run_case("prog_limit", -1, -1);

      // R8 boundary: exactly MP pulses still succeeds
      set_needs(1, 1);
      need_e[0] = MP;
      run_case("pulse_edge", -1, -1);

      // R3 boundary: success on the last allowed program attempt, last byte
      set_needs(1, 1);
      need_p[N - 1] = PT;
      run_case("prog_edge", -1, -1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got no end, expected run to finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule